// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Trimmed Seconds

This block turns a 32,768 Hz oscillator enable into a one-cycle seconds tick. It also corrects a crystal's frequency error without touching the crystal. A signed calibration code picks how many minutes of a repeating 64-minute correction cycle carry one adjusted second. A positive code shortens the first second of each chosen minute by one divide-by-256 step. A negative code lengthens it by half a step.

A 512 Hz square wave comes from a free-running tap that sits ahead of the correction. A production tester can therefore measure the raw oscillator error at that pin while any calibration value is loaded. A stop input freezes the whole divider chain.

The block also reports its position inside the correction cycle as a minute index. Calendar counting is left to a block downstream, which consumes the seconds tick.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the divider, the second-in-minute and minute counters and the prescale tap return to zero. The calibration inputs are latched, so after reset `sec_tick`, `minute_pos` and `sq512` read 0.
- R2: An unadjusted second lasts exactly OSC_HZ enabled oscillator ticks (32,768 by default). `sec_tick` pulses on the tick that completes it.
- R3: With the latched sign equal to 1, an adjusted second lasts OSC_HZ − 256 ticks.
- R4: With the latched sign equal to 0, an adjusted second lasts OSC_HZ + 128 ticks.
- R5: Only second 0 of minutes 0 through 2N−1 is adjusted, where N is the latched 5-bit magnitude. N = 0 adjusts nothing.
- R6: `minute_pos` counts minutes from 0 to 2^(CAL_W+1)−1 (63 by default), advancing after every SEC_PER_MIN seconds. It wraps to 0 after the last minute.
- R7: The calibration inputs are latched only at reset and at the wrap from the last minute to minute 0. A change at any other time takes effect from the next cycle start.
- R8: `sq512` is bit 5 of a free-running count of enabled ticks, a 512 Hz square wave at the default rate. Its phase and frequency do not depend on the calibration value.
- R9: While `halt` is 1, no counter advances: `sec_tick` stays 0, and `sq512` and `minute_pos` hold.
- R10: `sec_tick` is high only in a cycle where `osc_tick` is 1 and `halt` is 0. It is never high for two consecutive enabled ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| halt | input | 1 | Stop: freezes the divider chain |
| cal_mag | input | CAL_W | Calibration magnitude N |
| cal_pos | input | 1 | Calibration sign, 1 = speed up, 0 = slow down |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| minute_pos | output | CAL_W+1 | Minute index inside the correction cycle |
| sq512 | output | 1 | 512 Hz test square wave |

## Verification
`sec_tick` is combinational from the divider state and the current `osc_tick` and `halt`. It is due in the same cycle as the completing tick. `minute_pos` and `sq512` come from registers and change one clock edge after the enabling tick.

The bench drives its inputs just after the falling edge and compares the outputs 2 ns later, before the next rising edge. It then advances a model computed from the second-length rules. Each comparison therefore uses the inputs of that cycle and the state left by the previous edge.

A reduced configuration (512 ticks per second, 2 seconds per minute, 3-bit magnitude) makes whole 16-minute cycles short enough to sweep. The sweep covers both signs, magnitudes 0, 3 and 7, a mid-cycle code change, a half-rate oscillator enable and stop bursts.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        CAL_NONE  = 2'd0,
        CAL_SHORT = 2'd1,
        CAL_LONG  = 2'd2
    } cal_mode_e;

    // Length, in oscillator ticks, of the current second.
    function automatic int unsigned sec_len(input int unsigned base,
                                            input int unsigned step,
                                            input cal_mode_e   mode);
        case (mode)
            CAL_SHORT: return base - step;
            CAL_LONG:  return base + step / 2;
            default:   return base;
        endcase
    endfunction

endpackage

// File: rtl/rtc_ft_tap.sv
module rtc_ft_tap #(
    parameter int FT_DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sq
);
    localparam int PW = $clog2(FT_DIV);

    logic [PW-1:0] p_q;

    always_ff @(posedge clk) begin
        if (rst)     p_q <= '0;
        else if (en) p_q <= p_q + 1'b1;
    end

    assign sq = p_q[PW-1];

    a_r9_tap_frozen: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(p_q));
endmodule

// File: rtl/rtc_sec_div.sv
module rtc_sec_div
    import rtc_cal_pkg::*;
#(
    parameter int OSC_HZ = 32768,
    parameter int STEP   = 256,
    parameter int CNT_W  = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  cal_mode_e mode,
    output logic      sec_tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;
    logic             at_last;

    assign last_val = CNT_W'(sec_len(OSC_HZ, STEP, mode) - 1);
    assign at_last  = (cnt_q == last_val);
    assign sec_tick = en && at_last;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (en)      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

    a_r9_div_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));
    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(OSC_HZ + STEP / 2 - 1));
endmodule

// File: rtl/rtc_cal_sched.sv
module rtc_cal_sched
    import rtc_cal_pkg::*;
#(
    parameter int SEC_PER_MIN = 60,
    parameter int CAL_W       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_tick,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    output logic [CAL_W:0]   minute,
    output cal_mode_e        mode
);
    localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

    logic [SEC_W-1:0] sec_q;
    logic [CAL_W:0]   min_q;
    logic [CAL_W-1:0] mag_q;
    logic             pos_q;
    logic             min_end;
    logic             cyc_end;

    assign min_end = sec_tick && (sec_q == SEC_W'(SEC_PER_MIN - 1));
    assign cyc_end = min_end && (&min_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
            min_q <= '0;
            mag_q <= cal_mag;
            pos_q <= cal_pos;
        end else if (sec_tick) begin
            if (min_end) begin
                sec_q <= '0;
                min_q <= min_q + 1'b1;
                if (cyc_end) begin
                    mag_q <= cal_mag;
                    pos_q <= cal_pos;
                end
            end else begin
                sec_q <= sec_q + 1'b1;
            end
        end
    end

    always_comb begin
        mode = CAL_NONE;
        if (sec_q == '0 && min_q < {mag_q, 1'b0})
            mode = pos_q ? CAL_SHORT : CAL_LONG;
    end

    assign minute = min_q;

    a_r5_first_second: assert property (@(posedge clk) disable iff (rst)
        (mode != CAL_NONE) |-> (sec_q == '0));
    a_r7_code_held: assert property (@(posedge clk) disable iff (rst)
        !cyc_end |=> ($stable(mag_q) && $stable(pos_q)));
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        cyc_end |=> (min_q == '0));
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
    import rtc_cal_pkg::*;
#(
    parameter int OSC_HZ      = 32768,
    parameter int SEC_PER_MIN = 60,
    parameter int CAL_W       = 5,
    parameter int STEP        = 256,
    parameter int FT_DIV      = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             halt,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    output logic             sec_tick,
    output logic [CAL_W:0]   minute_pos,
    output logic             sq512
);
    localparam int CNT_W = $clog2(OSC_HZ + STEP / 2 + 1);

    logic      en;
    cal_mode_e mode;

    assign en = osc_tick && !halt;

    rtc_ft_tap #(.FT_DIV(FT_DIV)) u_tap (
        .clk(clk), .rst(rst), .en(en), .sq(sq512)
    );

    rtc_sec_div #(.OSC_HZ(OSC_HZ), .STEP(STEP), .CNT_W(CNT_W)) u_div (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .sec_tick(sec_tick)
    );

    rtc_cal_sched #(.SEC_PER_MIN(SEC_PER_MIN), .CAL_W(CAL_W)) u_sched (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .cal_mag(cal_mag), .cal_pos(cal_pos),
        .minute(minute_pos), .mode(mode)
    );

    a_r10_tick_gated: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> (osc_tick && !halt));
    a_r10_no_double: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && en) |=> !(sec_tick && en));
endmodule

// File: tb/rtc_cal_prescaler_test.sv
module rtc_cal_prescaler_test;
    localparam int OSC  = 512;
    localparam int SPM  = 2;
    localparam int CW   = 3;
    localparam int MINS = 1 << (CW + 1);

    logic clk = 0;
    logic rst, osc_tick, halt, cal_pos;
    logic [CW-1:0] cal_mag;
    logic sec_tick, sq512;
    logic [CW:0] minute_pos;

    always #4 clk = ~clk;

    rtc_cal_prescaler #(.OSC_HZ(OSC), .SEC_PER_MIN(SPM), .CAL_W(CW)) uut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .halt(halt),
        .cal_mag(cal_mag), .cal_pos(cal_pos),
        .sec_tick(sec_tick), .minute_pos(minute_pos), .sq512(sq512)
    );

    int vectors = 0, errors = 0, cycles = 0;
    int m_cnt, m_sec, m_min, m_mag, m_p;
    bit m_pos;
    string ctx = "R1";

    task automatic chk(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit o, input bit h, input bit r);
        int len;
        bit en, exp_tick;
        string t;
        @(negedge clk);
        osc_tick = o; halt = h; rst = r;
        cycles++;
        #2;
        en = o && !h;
        len = OSC;
        if (m_sec == 0 && m_min < 2 * m_mag) len = m_pos ? OSC - 256 : OSC + 128;
        exp_tick = en && (m_cnt == len - 1);
        t = (len < OSC) ? "R3/R5" : (len > OSC) ? "R4/R5" : "R2";
        chk(sec_tick, exp_tick, $sformatf("%s %s sec_tick", t, ctx));
        chk(minute_pos, m_min, $sformatf("R6 %s minute_pos", ctx));
        chk(sq512, (m_p >> 5) & 1, $sformatf("R8 %s sq512", ctx));
        if (r) begin
            m_cnt = 0; m_sec = 0; m_min = 0; m_p = 0;
            m_mag = cal_mag; m_pos = cal_pos;
        end else if (en) begin
            m_p = (m_p + 1) % 64;
            if (exp_tick) begin
                m_cnt = 0;
                if (m_sec == SPM - 1) begin
                    m_sec = 0;
                    if (m_min == MINS - 1) begin
                        m_min = 0; m_mag = cal_mag; m_pos = cal_pos;
                    end else m_min++;
                end else m_sec++;
            end else m_cnt++;
        end
    endtask

    task automatic run(input int n, input int pattern);
        for (int i = 0; i < n; i++) begin
            if (pattern == 1) step(i % 2 == 0, 1'b0, 1'b0);
            else if (pattern == 2) step(1'b1, (i % 3000) < 50, 1'b0);
            else step(1'b1, 1'b0, 1'b0);
        end
    endtask

    initial begin
        m_cnt = 0; m_sec = 0; m_min = 0; m_p = 0; m_mag = 0; m_pos = 0;
        osc_tick = 0; halt = 0; rst = 1; cal_mag = 3; cal_pos = 1;
        repeat (3) step(1'b1, 1'b0, 1'b1);
        // R1: outputs idle right after reset
        ctx = "R1"; step(1'b0, 1'b0, 1'b0);
        ctx = "R3 pos3"; run(17000, 0);
        cal_mag = 7; cal_pos = 0;
        ctx = "R7 mid-cycle neg7"; run(20000, 0);
        ctx = "R10 half-rate"; run(24000, 1);
        ctx = "R9 halt bursts"; run(20000, 2);
        cal_mag = 7; cal_pos = 1;
        ctx = "R3 pos7"; run(30000, 0);
        cal_mag = 0; cal_pos = 0;
        ctx = "R5 zero"; run(20000, 0);
        cal_mag = 2; cal_pos = 0;
        ctx = "R4 neg2"; run(20000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1_560_000;
        errors++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule